// File: doc/BRIEF.md
# Operand addressing-byte parser

This block sits behind an instruction-length front end. It takes the operand-addressing bytes of one instruction, one byte per accepted transfer. It starts at the byte that carries the mod, reg and r/m fields and stops after the last displacement byte. It reports whether the operand is a register or a memory reference. It also reports which base and index registers are used, the index scale, and the displacement, sign-extended to 32 bits. A completion pulse carries the total number of bytes consumed.

The effective address is formed from a snapshot of the eight general registers supplied on a flat input bus. It follows the wrap-around rules of the active address width. The width is either 16-bit or 32-bit. It is taken as the default mode input XOR a per-instruction size-override input, latched together with the first byte. The 16-bit form uses a fixed table of base/index pairs with no scale and no scale-index-base byte. The 32-bit form may pull in a scale-index-base byte. Both forms have the quirk that one memory code with mod=00 selects an absolute displacement instead of a base register.

Top module: `addr_byte_parser`

## Requirements
- R1: The first byte is split as mod = bits 7:6, reg = bits 5:3, r/m = bits 2:0. `reg_field` always reports bits 5:3 of that byte, whatever the mode.
- R2: mod = 3 gives a register operand. The parse completes after 1 byte with `is_reg` = 1, no base and no index, `disp` = 0 and `eff_addr` = 0.
- R3: mod = 0 adds no displacement. mod = 1 adds one byte, sign-extended. mod = 2 adds 2 bytes under 16-bit width and 4 bytes under 32-bit width. Displacement bytes arrive least significant first, and `disp` is sign-extended to 32 bits.
- R4: With mod = 0, r/m = 6 under 16-bit width is an absolute 2-byte displacement with no base. With mod = 0, r/m = 5 under 32-bit width is an absolute 4-byte displacement with no base.
- R5: Under 32-bit width, mod != 3 with r/m = 4 means a scale-index-base byte follows. In that byte, scale is bits 7:6 (multiplier 2^scale), index is bits 5:3 and base is bits 2:0. Otherwise r/m names the base register directly.
- R6: A scale-index-base index code of 4 means no index. A base code of 5 with mod = 0 means no base, followed by a 4-byte displacement. With mod = 1 or 2, base code 5 names register 5.
- R7: Under 16-bit width, r/m codes 0..7 select base/index as 3+6, 3+7, 5+6, 5+7, 6, 7, 5 and 3 (register numbers). The scale is always 0 and no scale-index-base byte is read.
- R8: The width is 32-bit when `mode32` XOR `size_ovr` is 1. Both are sampled only with the first byte, and later changes do not affect the parse in progress.
- R9: `eff_addr` = base + (index << scale) + disp, where an absent register counts as 0. Register n is `regs_flat[32n+31:32n]`. Under 32-bit width the sum wraps modulo 2^32. Under 16-bit width only the low 16 bits of each term are summed, modulo 2^16, and bits 31:16 are 0.
- R10: `done` is high for exactly one cycle, the cycle after the last byte is accepted. During that cycle `in_ready` is 0 and `byte_count` is 1..6. All results hold until the first byte of the next parse is accepted.
- R11: Cycles with `byte_valid` low are ignored. Neither the data nor the parse state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | Byte on `byte_data` is offered |
| byte_data | input | 8 | Instruction byte |
| mode32 | input | 1 | Default address width is 32-bit |
| size_ovr | input | 1 | Size override, inverts the default width |
| regs_flat | input | 256 | Register snapshot, register n at bits 32n+31:32n |
| in_ready | output | 1 | Byte can be accepted this cycle |
| done | output | 1 | Parse complete, results valid |
| byte_count | output | 3 | Bytes consumed by the parse |
| is_reg | output | 1 | Operand is a register |
| reg_field | output | 3 | reg field of the first byte |
| base_valid | output | 1 | A base register is used |
| base_sel | output | 3 | Base register number |
| index_valid | output | 1 | An index register is used |
| index_sel | output | 3 | Index register number |
| scale | output | 2 | Index scale exponent |
| disp | output | 32 | Sign-extended displacement |
| eff_addr | output | 32 | Effective address |

## Verification
A wrong remaining-byte count or a stale width latch appears at the ports as a `done` pulse one cycle early or late, and as a `byte_count` that does not match the number of bytes driven. Both show in the same transaction. A wrong byte position in the displacement register shows as a swapped or mis-extended `disp`, and through it a wrong `eff_addr`, in the `done` cycle. A wrong pair-table entry shows only as a wrong base or index number and address for that one r/m code. For that reason every code is driven in both widths.

// File: rtl/adp_pkg.sv
package adp_pkg;

  localparam int ADP_AW    = 32;
  localparam int ADP_NREG  = 8;
  localparam int ADP_SEL_W = $clog2(ADP_NREG);
  localparam int ADP_CNT_W = 3;
  localparam int ADP_RF_W  = ADP_AW * ADP_NREG;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SIB  = 2'd1,
    ST_DISP = 2'd2,
    ST_DONE = 2'd3
  } adp_state_e;

  typedef struct packed {
    logic                 base_v;
    logic [ADP_SEL_W-1:0] base_sel;
    logic                 idx_v;
    logic [ADP_SEL_W-1:0] idx_sel;
    logic [1:0]           scale;
  } adp_sel_t;

  // Sign-extend a little-endian displacement of nbytes bytes.
  function automatic logic [ADP_AW-1:0] adp_sext(input logic [ADP_AW-1:0] raw,
                                                 input logic [ADP_CNT_W-1:0] nbytes);
    case (nbytes)
      3'd1:    return {{(ADP_AW-8){raw[7]}}, raw[7:0]};
      3'd2:    return {{(ADP_AW-16){raw[15]}}, raw[15:0]};
      3'd4:    return raw;
      default: return '0;
    endcase
  endfunction

  function automatic logic [ADP_AW-1:0] adp_sum_wide(input logic [ADP_AW-1:0] b,
                                                     input logic [ADP_AW-1:0] x,
                                                     input logic [1:0]        sc,
                                                     input logic [ADP_AW-1:0] d);
    return b + (x << sc) + d;
  endfunction

  function automatic logic [15:0] adp_sum_narrow(input logic [15:0] b,
                                                 input logic [15:0] x,
                                                 input logic [15:0] d);
    return b + x + d;
  endfunction

endpackage

// File: rtl/adp_lead_decode.sv
module adp_lead_decode
  import adp_pkg::*;
(
  input  logic [7:0]           lead,
  input  logic                 wide,
  output logic                 is_reg,
  output logic                 need_sib,
  output adp_sel_t             sel,
  output logic [ADP_CNT_W-1:0] dlen
);
  logic [1:0] md;
  logic [2:0] rm;
  assign md = lead[7:6];
  assign rm = lead[2:0];

  always_comb begin
    is_reg   = 1'b0;
    need_sib = 1'b0;
    sel      = '0;
    dlen     = '0;
    if (md == 2'b11) begin
      is_reg = 1'b1;
    end else if (wide) begin
      dlen = (md == 2'b01) ? 3'd1 : (md == 2'b10) ? 3'd4 : 3'd0;
      if (rm == 3'd4) begin
        need_sib = 1'b1;
      end else if (md == 2'b00 && rm == 3'd5) begin
        dlen = 3'd4;
      end else begin
        sel.base_v   = 1'b1;
        sel.base_sel = rm;
      end
    end else begin
      dlen = (md == 2'b01) ? 3'd1 : (md == 2'b10) ? 3'd2 : 3'd0;
      case (rm)
        3'd0: begin sel.base_v = 1'b1; sel.base_sel = 3'd3; sel.idx_v = 1'b1; sel.idx_sel = 3'd6; end
        3'd1: begin sel.base_v = 1'b1; sel.base_sel = 3'd3; sel.idx_v = 1'b1; sel.idx_sel = 3'd7; end
        3'd2: begin sel.base_v = 1'b1; sel.base_sel = 3'd5; sel.idx_v = 1'b1; sel.idx_sel = 3'd6; end
        3'd3: begin sel.base_v = 1'b1; sel.base_sel = 3'd5; sel.idx_v = 1'b1; sel.idx_sel = 3'd7; end
        3'd4: begin sel.base_v = 1'b1; sel.base_sel = 3'd6; end
        3'd5: begin sel.base_v = 1'b1; sel.base_sel = 3'd7; end
        3'd6: begin
          if (md == 2'b00) dlen = 3'd2;
          else begin sel.base_v = 1'b1; sel.base_sel = 3'd5; end
        end
        default: begin sel.base_v = 1'b1; sel.base_sel = 3'd3; end
      endcase
    end
  end

  // R7: the 16-bit form never asks for a scale-index-base byte
  always_comb begin
    if (!wide) assert (!need_sib) else $error("p_no_sib_narrow_r7");
  end

endmodule

// File: rtl/adp_sib_decode.sv
module adp_sib_decode
  import adp_pkg::*;
(
  input  logic [7:0]           sib,
  input  logic [1:0]           md,
  output adp_sel_t             sel,
  output logic [ADP_CNT_W-1:0] dlen
);
  logic abs_base;
  assign abs_base = (md == 2'b00) && (sib[2:0] == 3'd5);

  always_comb begin
    sel.scale    = sib[7:6];
    sel.idx_sel  = sib[5:3];
    sel.idx_v    = (sib[5:3] != 3'd4);
    sel.base_sel = sib[2:0];
    sel.base_v   = !abs_base;
    if (abs_base)          dlen = 3'd4;
    else if (md == 2'b01)  dlen = 3'd1;
    else if (md == 2'b10)  dlen = 3'd4;
    else                   dlen = 3'd0;
  end

  // R6: an absolute base always brings a 4-byte displacement
  always_comb begin
    if (!sel.base_v) assert (dlen == 3'd4) else $error("p_abs_base_disp_r6");
  end

endmodule

// File: rtl/adp_ea_calc.sv
module adp_ea_calc
  import adp_pkg::*;
(
  input  logic [ADP_RF_W-1:0] regs_flat,
  input  adp_sel_t            sel,
  input  logic [ADP_AW-1:0]   disp,
  input  logic                wide,
  input  logic                is_reg,
  output logic [ADP_AW-1:0]   ea
);
  logic [ADP_AW-1:0] reg_arr [ADP_NREG];
  logic [ADP_AW-1:0] base_val;
  logic [ADP_AW-1:0] idx_val;
  logic [15:0]       narrow_sum;

  for (genvar g = 0; g < ADP_NREG; g++) begin : g_unpack
    assign reg_arr[g] = regs_flat[g*ADP_AW +: ADP_AW];
  end

  assign base_val   = sel.base_v ? reg_arr[sel.base_sel] : '0;
  assign idx_val    = sel.idx_v  ? reg_arr[sel.idx_sel]  : '0;
  assign narrow_sum = adp_sum_narrow(base_val[15:0], idx_val[15:0], disp[15:0]);

  always_comb begin
    if (is_reg)    ea = '0;
    else if (wide) ea = adp_sum_wide(base_val, idx_val, sel.scale, disp);
    else           ea = {{(ADP_AW-16){1'b0}}, narrow_sum};
  end

endmodule

// File: rtl/addr_byte_parser.sv
module addr_byte_parser
  import adp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 byte_valid,
  input  logic [7:0]           byte_data,
  input  logic                 mode32,
  input  logic                 size_ovr,
  input  logic [ADP_RF_W-1:0]  regs_flat,
  output logic                 in_ready,
  output logic                 done,
  output logic [ADP_CNT_W-1:0] byte_count,
  output logic                 is_reg,
  output logic [ADP_SEL_W-1:0] reg_field,
  output logic                 base_valid,
  output logic [ADP_SEL_W-1:0] base_sel,
  output logic                 index_valid,
  output logic [ADP_SEL_W-1:0] index_sel,
  output logic [1:0]           scale,
  output logic [ADP_AW-1:0]    disp,
  output logic [ADP_AW-1:0]    eff_addr
);
  localparam int POS_W = $clog2(ADP_AW / 8);

  adp_state_e           state_q, state_d;
  logic                 wide_q, is_reg_q;
  logic [1:0]           mod_q;
  logic [2:0]           reg_q;
  adp_sel_t             sel_q;
  logic [ADP_CNT_W-1:0] dlen_q, left_q, cnt_q;
  logic [POS_W-1:0]     pos_q;
  logic [ADP_AW-1:0]    raw_q;

  // named internal events
  logic wide_now, accept, ev_lead, ev_sib, ev_disp, ev_last;

  logic                 ld_is_reg, ld_need_sib;
  adp_sel_t             ld_sel, sb_sel;
  logic [ADP_CNT_W-1:0] ld_dlen, sb_dlen;

  assign wide_now = mode32 ^ size_ovr;
  assign in_ready = (state_q != ST_DONE);
  assign accept   = byte_valid && in_ready;
  assign ev_lead  = accept && (state_q == ST_IDLE);
  assign ev_sib   = accept && (state_q == ST_SIB);
  assign ev_disp  = accept && (state_q == ST_DISP);
  assign ev_last  = (state_d == ST_DONE) && (state_q != ST_DONE);

  adp_lead_decode u_lead (
    .lead     (byte_data),
    .wide     (wide_now),
    .is_reg   (ld_is_reg),
    .need_sib (ld_need_sib),
    .sel      (ld_sel),
    .dlen     (ld_dlen)
  );

  adp_sib_decode u_sib (
    .sib  (byte_data),
    .md   (mod_q),
    .sel  (sb_sel),
    .dlen (sb_dlen)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (ev_lead) begin
        if (ld_is_reg)          state_d = ST_DONE;
        else if (ld_need_sib)   state_d = ST_SIB;
        else if (ld_dlen != 0)  state_d = ST_DISP;
        else                    state_d = ST_DONE;
      end
      ST_SIB:  if (ev_sib)  state_d = (sb_dlen != 0) ? ST_DISP : ST_DONE;
      ST_DISP: if (ev_disp && left_q == 3'd1) state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      wide_q   <= 1'b0;
      is_reg_q <= 1'b0;
      mod_q    <= '0;
      reg_q    <= '0;
      sel_q    <= '0;
      dlen_q   <= '0;
      left_q   <= '0;
      cnt_q    <= '0;
      pos_q    <= '0;
      raw_q    <= '0;
    end else begin
      state_q <= state_d;
      if (ev_lead) begin
        wide_q   <= wide_now;
        is_reg_q <= ld_is_reg;
        mod_q    <= byte_data[7:6];
        reg_q    <= byte_data[5:3];
        sel_q    <= ld_sel;
        dlen_q   <= ld_dlen;
        left_q   <= ld_dlen;
        cnt_q    <= 3'd1;
        pos_q    <= '0;
        raw_q    <= '0;
      end
      if (ev_sib) begin
        sel_q  <= sb_sel;
        dlen_q <= sb_dlen;
        left_q <= sb_dlen;
        cnt_q  <= cnt_q + 3'd1;
      end
      if (ev_disp) begin
        raw_q[{pos_q, 3'b000} +: 8] <= byte_data;
        pos_q  <= pos_q + 1'b1;
        left_q <= left_q - 3'd1;
        cnt_q  <= cnt_q + 3'd1;
      end
    end
  end

  assign done        = (state_q == ST_DONE);
  assign byte_count  = cnt_q;
  assign is_reg      = is_reg_q;
  assign reg_field   = reg_q;
  assign base_valid  = sel_q.base_v;
  assign base_sel    = sel_q.base_sel;
  assign index_valid = sel_q.idx_v;
  assign index_sel   = sel_q.idx_sel;
  assign scale       = sel_q.scale;
  assign disp        = adp_sext(raw_q, dlen_q);

  adp_ea_calc u_ea (
    .regs_flat (regs_flat),
    .sel       (sel_q),
    .disp      (disp),
    .wide      (wide_q),
    .is_reg    (is_reg_q),
    .ea        (eff_addr)
  );

  // R10: completion is a single-cycle pulse, following the last byte
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_follows_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_last |=> done);
  p_count_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (byte_count >= 3'd1 && byte_count <= 3'd6));
  // R2: a register operand is one byte with no displacement
  p_reg_one_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_reg) |-> (byte_count == 3'd1 && disp == '0 && !base_valid));
  // R7: 16-bit form has no scale and at most three bytes
  p_narrow_noscale_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wide_q) |-> (scale == 2'd0 && byte_count <= 3'd3));
  // R5: the scale-index-base state is reached only under 32-bit width
  p_sib_only_wide_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SIB) |-> wide_q);
  // R9: 16-bit addresses never carry upper bits
  p_ea16_zext_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wide_q) |-> (eff_addr[31:16] == 16'h0));
  // R11: an idle input cycle changes nothing inside a displacement
  p_gap_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DISP && !byte_valid) |=> (state_q == ST_DISP && $stable(raw_q) && $stable(cnt_q)));
  // R10: results hold while waiting for the next first byte
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !byte_valid) |=> ($stable(disp) && $stable(byte_count)));

endmodule

// File: tb/addr_byte_parser_tb.sv
module addr_byte_parser_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         byte_valid = 1'b0;
  logic [7:0]   byte_data = 8'h0;
  logic         mode32 = 1'b0;
  logic         size_ovr = 1'b0;
  logic [255:0] regs_flat;
  logic         in_ready, done, is_reg, base_valid, index_valid;
  logic [2:0]   byte_count, reg_field, base_sel, index_sel;
  logic [1:0]   scale;
  logic [31:0]  disp, eff_addr;

  logic [31:0] rf [8];
  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb for (int i = 0; i < 8; i++) regs_flat[i*32 +: 32] = rf[i];

  addr_byte_parser u_dut (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
    .mode32(mode32), .size_ovr(size_ovr), .regs_flat(regs_flat),
    .in_ready(in_ready), .done(done), .byte_count(byte_count), .is_reg(is_reg),
    .reg_field(reg_field), .base_valid(base_valid), .base_sel(base_sel),
    .index_valid(index_valid), .index_sel(index_sel), .scale(scale),
    .disp(disp), .eff_addr(eff_addr)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] sx(input logic [31:0] v, input int nb);
    if (nb == 1) return {{24{v[7]}}, v[7:0]};
    if (nb == 2) return {{16{v[15]}}, v[15:0]};
    if (nb == 4) return v;
    return 32'h0;
  endfunction

  task automatic gap();
    repeat ($urandom_range(0, 2)) begin
      @(negedge clk);
      byte_valid = 1'b0;
      byte_data  = 8'($urandom);
    end
  endtask

  task automatic run_txn(input string tag, input logic [7:0] b0, input logic m32,
                         input logic ovr, input logic [7:0] sb, input logic [31:0] dv);
    logic       wide, isr, bv, iv;
    logic [1:0] md, sc;
    logic [2:0] rm, bs, xs;
    int         dl;
    logic [7:0] q [$];
    logic [31:0] dsx, e, bval, xval;
    logic [15:0] t;
    wide = m32 ^ ovr; md = b0[7:6]; rm = b0[2:0];
    isr = (md == 2'd3); bv = 0; iv = 0; bs = 0; xs = 0; sc = 0; dl = 0;
    q.push_back(b0);
    if (!isr && wide) begin
      dl = (md == 1) ? 1 : (md == 2) ? 4 : 0;
      if (rm == 3'd4) begin
        q.push_back(sb);
        sc = sb[7:6]; xs = sb[5:3]; iv = (xs != 3'd4);
        if (md == 0 && sb[2:0] == 3'd5) dl = 4;
        else begin bv = 1; bs = sb[2:0]; end
      end else if (md == 0 && rm == 3'd5) dl = 4;
      else begin bv = 1; bs = rm; end
    end else if (!isr) begin
      dl = (md == 1) ? 1 : (md == 2) ? 2 : 0;
      if (md == 0 && rm == 3'd6) dl = 2;
      else begin
        bv = 1;
        case (rm)
          3'd4: bs = 6;
          3'd5: bs = 7;
          3'd2, 3'd3, 3'd6: bs = 5;
          default: bs = 3;
        endcase
        if (rm < 4) begin iv = 1; xs = rm[0] ? 3'd7 : 3'd6; end
      end
    end
    for (int k = 0; k < dl; k++) q.push_back(dv[8*k +: 8]);
    dsx  = sx(dv, dl);
    bval = bv ? rf[bs] : 32'h0;
    xval = iv ? rf[xs] : 32'h0;
    if (isr) e = 32'h0;
    else if (wide) e = bval + (xval << sc) + dsx;
    else begin t = bval[15:0] + xval[15:0] + dsx[15:0]; e = {16'h0, t}; end

    mode32 = m32; size_ovr = ovr;
    gap();
    foreach (q[i]) begin
      @(negedge clk);
      if (i > 0) chk({tag, " R10 early done"}, {31'h0, done}, 32'h0);
      byte_valid = 1'b1;
      byte_data  = q[i];
      @(posedge clk);
      #1;
      byte_valid = 1'b0;
      // R8: width inputs changing mid-parse must not matter
      mode32 = 1'($urandom); size_ovr = 1'($urandom);
      byte_data = 8'($urandom);
      if (i + 1 < q.size()) gap();
    end
    @(negedge clk);
    chk({tag, " R10 done"},        {31'h0, done},        32'h1);
    chk({tag, " R10 in_ready"},    {31'h0, in_ready},    32'h0);
    chk({tag, " R10 byte_count"},  {29'h0, byte_count},  q.size());
    chk({tag, " R2 is_reg"},       {31'h0, is_reg},      {31'h0, isr});
    chk({tag, " R1 reg_field"},    {29'h0, reg_field},   {29'h0, b0[5:3]});
    chk({tag, " R5 base_valid"},   {31'h0, base_valid},  {31'h0, bv});
    if (bv) chk({tag, " R7 base_sel"}, {29'h0, base_sel}, {29'h0, bs});
    chk({tag, " R6 index_valid"},  {31'h0, index_valid}, {31'h0, iv});
    if (iv) chk({tag, " R7 index_sel"}, {29'h0, index_sel}, {29'h0, xs});
    chk({tag, " R5 scale"},        {30'h0, scale},       {30'h0, sc});
    chk({tag, " R3 disp"},         disp,                 dsx);
    chk({tag, " R9 eff_addr"},     eff_addr,             e);
  endtask

  task automatic rand_regs();
    for (int i = 0; i < 8; i++) rf[i] = $urandom;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) rf[i] = 32'h1000_0000 * i + 32'h0101 * i;
    repeat (3) @(negedge clk);
    chk("R10 reset done",     {31'h0, done},     32'h0);
    chk("R10 reset in_ready", {31'h0, in_ready}, 32'h1);
    chk("R10 reset count",    {29'h0, byte_count}, 32'h0);
    rst_n = 1'b1;

    run_txn("R2 reg",        8'hC1, 1'b0, 1'b0, 8'h00, 32'h0);
    run_txn("R2 reg32",      8'hFF, 1'b1, 1'b0, 8'h00, 32'h0);
    run_txn("R4 abs16",      8'h06, 1'b0, 1'b0, 8'h00, 32'h0000_BEEF);
    run_txn("R4 abs32",      8'h05, 1'b1, 1'b0, 8'h00, 32'h1234_5678);
    run_txn("R6 noidx",      8'h04, 1'b1, 1'b0, 8'h23, 32'h0);
    run_txn("R6 absbase",    8'h04, 1'b1, 1'b0, 8'h95, 32'h8000_0010);
    run_txn("R6 base5d8",    8'h44, 1'b1, 1'b0, 8'h95, 32'h0000_00F0);
    run_txn("R3 neg8",       8'h47, 1'b0, 1'b0, 8'h00, 32'h0000_0080);
    run_txn("R5 sibd32",     8'h8C, 1'b1, 1'b0, 8'hFA, 32'hFFFF_FFFC);
    rf[3] = 32'h0001_FFFF; rf[6] = 32'h0000_0002;
    run_txn("R9 wrap16",     8'h80, 1'b0, 1'b0, 8'h00, 32'h0000_0010);
    rf[0] = 32'hFFFF_FFF0; rf[1] = 32'h0000_0004;
    run_txn("R9 wrap32",     8'h84, 1'b1, 1'b0, 8'hC8, 32'h0000_0001);
    run_txn("R8 ovr16to32",  8'h84, 1'b0, 1'b1, 8'hC8, 32'h0BAD_F00D);
    run_txn("R8 ovr32to16",  8'h84, 1'b1, 1'b1, 8'hC8, 32'h0000_7FFE);
    for (int r = 0; r < 8; r++) begin
      rand_regs();
      run_txn("R7 table", {2'b10, 3'(r), 3'(r)}, 1'b0, 1'b0, 8'h00, $urandom);
      run_txn("R5 direct", {2'b01, 3'(r), 3'(r)}, 1'b1, 1'b0, 8'($urandom), $urandom);
    end
    // R10 and R11: results hold through idle cycles with junk on the data lines
    run_txn("R10 hold", 8'h87, 1'b0, 1'b0, 8'h00, 32'h0000_9ABC);
    held = disp;
    repeat (4) begin
      @(negedge clk);
      byte_data = 8'($urandom);
    end
    chk("R11 held disp", disp, held);
    chk("R11 held count", {29'h0, byte_count}, 32'h3);

    for (int n = 0; n < 300; n++) begin
      rand_regs();
      run_txn("rnd", 8'($urandom), 1'($urandom), 1'($urandom), 8'($urandom), $urandom);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule